// File: doc/BRIEF.md
# Retire-Stream Signature Comparator

This block sits at the retire stage of one core in a pair of cores that run the same instruction stream. Each cycle it can accept one retired result: a register writeback value, a branch target, a load address, a store address or a store value. The result carries a small kind code. The block folds the kind code and the 64-bit value into a running CRC-32 signature. The signature is narrow, so the two cores can exchange it cheaply instead of trading every raw result.

The checking interval is a programmable number of accepted items. When the last item of an interval is accepted, the block does four things: it latches the signature and the interval number as the local outgoing signature, pulses an interval-done strobe, reseeds the accumulator and starts the next interval. The partner core's signature arrives on a separate valid/value/index channel. When a local signature and a partner signature are both pending, the block compares them. Any disagreement sets a sticky error flag, which stays set until software clears it. When redundant mode is off, the block ignores both channels, resets its interval state and keeps the error flag low.

Top module: `fp_sig_cmp`

## Requirements
- R1: While reset is asserted, err_flag and ivl_done are 0, loc_sig is 0x00000000 and loc_idx is 0.
- R2: For each accepted item (red_en=1, ret_vld=1) the accumulator is updated with CRC-32. The generator is 0x04C11DB7, the seed is 0xFFFFFFFF, and there is no bit reflection and no final inversion. Each update shifts in 67 message bits, most significant first: the 3-bit ret_kind, then the 64-bit ret_val.
- R3: A cycle with ret_vld=0 leaves the accumulator unchanged. The same value with a different ret_kind gives a different signature.
- R4: When the accepted item brings the interval's item count to ivl_len, the interval ends; an ivl_len of 0 acts as 1. In the next cycle ivl_done is high for one cycle, loc_sig holds the interval's signature and loc_idx holds the interval number. Interval numbers count from 0 and wrap modulo 16.
- R5: At each interval end the accumulator is reseeded to 0xFFFFFFFF and the item count returns to 0. Two intervals with identical item streams therefore produce identical signatures.
- R6: A partner signature is captured when peer_vld=1. When a local signature and a partner signature are both pending, they are compared and both slots are freed. A difference in either the signature or the interval index sets err_flag one cycle later.
- R7: err_flag stays set until err_clr=1 is applied. If a mismatch and err_clr occur in the same cycle, the flag stays set.
- R8: While red_en=0, items and partner signatures are ignored, ivl_done stays 0 and err_flag is 0. The interval number restarts at 0 when red_en returns to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| red_en | input | 1 | Redundant mode enable |
| err_clr | input | 1 | Clears the sticky error flag |
| ivl_len | input | 16 | Items per checking interval (0 acts as 1) |
| ret_vld | input | 1 | A retired item is presented this cycle |
| ret_kind | input | 3 | Kind code of the retired item |
| ret_val | input | 64 | Value, address or data of the retired item |
| peer_vld | input | 1 | Partner signature present this cycle |
| peer_sig | input | 32 | Partner signature |
| peer_idx | input | 4 | Partner interval number |
| loc_sig | output | 32 | Latched local signature of the last interval |
| loc_idx | output | 4 | Interval number of loc_sig |
| ivl_done | output | 1 | One-cycle strobe after an interval ends |
| err_flag | output | 1 | Sticky signature mismatch flag |

## Verification
The assertions check four behaviours on every cycle: the accumulator holds on idle cycles, it has been reseeded whenever the interval strobe is high, a pending mismatch raises the error flag, and the flag holds until it is cleared. They also check that disabling the mode drops both the strobe and the flag. The correctness of the CRC arithmetic, the interval length with its zero case, index wrap, and the kind code changing the signature can only be shown by the bench's scenarios. Those scenarios run against a behavioural model that is compared on every clock.

// File: rtl/fp_sig_cmp.sv
module fp_sig_cmp #(
  parameter int DATA_W = 64,
  parameter int KIND_W = 3,
  parameter int SIG_W  = 32,
  parameter int CNT_W  = 16,
  parameter int IDX_W  = 4,
  parameter logic [SIG_W-1:0] POLY = 32'h04C11DB7,
  parameter logic [SIG_W-1:0] SEED = 32'hFFFFFFFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              red_en,
  input  logic              err_clr,
  input  logic [CNT_W-1:0]  ivl_len,
  input  logic              ret_vld,
  input  logic [KIND_W-1:0] ret_kind,
  input  logic [DATA_W-1:0] ret_val,
  input  logic              peer_vld,
  input  logic [SIG_W-1:0]  peer_sig,
  input  logic [IDX_W-1:0]  peer_idx,
  output logic [SIG_W-1:0]  loc_sig,
  output logic [IDX_W-1:0]  loc_idx,
  output logic              ivl_done,
  output logic              err_flag
);
  localparam int MSG_W = KIND_W + DATA_W;

  function automatic logic [SIG_W-1:0] crc_fold(input logic [SIG_W-1:0] c_in,
                                               input logic [MSG_W-1:0] m);
    logic [SIG_W-1:0] c;
    logic fb;
    c = c_in;
    for (int i = MSG_W - 1; i >= 0; i--) begin
      fb = c[SIG_W-1] ^ m[i];
      c  = {c[SIG_W-2:0], 1'b0} ^ (fb ? POLY : '0);
    end
    return c;
  endfunction

  logic [SIG_W-1:0] acc, psig;
  logic [CNT_W-1:0] cnt;
  logic [IDX_W-1:0] idx, pidx;
  logic             lv, pv, err;

  logic [SIG_W-1:0] acc_nxt;
  logic [CNT_W:0]   cnt_inc;
  logic             hit, cmp, mism;

  assign acc_nxt  = crc_fold(acc, {ret_kind, ret_val});
  assign cnt_inc  = {1'b0, cnt} + 1'b1;
  assign hit      = ret_vld && (cnt_inc >= {1'b0, ivl_len});
  assign cmp      = lv && pv;
  assign mism     = cmp && ((loc_sig != psig) || (loc_idx != pidx));
  assign err_flag = err;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc      <= SEED;
      cnt      <= '0;
      idx      <= '0;
      loc_sig  <= '0;
      loc_idx  <= '0;
      ivl_done <= 1'b0;
      lv       <= 1'b0;
      pv       <= 1'b0;
      psig     <= '0;
      pidx     <= '0;
      err      <= 1'b0;
    end else if (!red_en) begin
      acc      <= SEED;
      cnt      <= '0;
      idx      <= '0;
      ivl_done <= 1'b0;
      lv       <= 1'b0;
      pv       <= 1'b0;
      err      <= 1'b0;
    end else begin
      ivl_done <= hit;
      if (ret_vld) begin
        if (hit) begin
          acc     <= SEED;
          cnt     <= '0;
          loc_sig <= acc_nxt;
          loc_idx <= idx;
          idx     <= idx + 1'b1;
        end else begin
          acc <= acc_nxt;
          cnt <= cnt_inc[CNT_W-1:0];
        end
      end
      lv <= (lv && !cmp) || hit;
      pv <= (pv && !cmp) || peer_vld;
      if (peer_vld) begin
        psig <= peer_sig;
        pidx <= peer_idx;
      end
      if (mism)         err <= 1'b1;
      else if (err_clr) err <= 1'b0;
    end
  end

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (red_en && !ret_vld) |=> $stable(acc)); // R3
  AST_RESEED: assert property (@(posedge clk) disable iff (!rst_n)
    ivl_done |-> (acc == SEED && cnt == '0)); // R5
  AST_MISMATCH_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (red_en && lv && pv && (loc_sig != psig)) |=> err_flag); // R6
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (red_en && err_flag && !err_clr) |=> err_flag); // R7
  AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !red_en |=> (!err_flag && !ivl_done)); // R8
endmodule

// File: tb/fp_sig_cmp_tb.sv
module fp_sig_cmp_tb_top;
  localparam bit [31:0] P_GEN  = 32'h04C11DB7;
  localparam bit [31:0] P_INIT = 32'hFFFFFFFF;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n = 1'b0, red_en = 1'b0, err_clr = 1'b0;
  logic [15:0] ivl_len = 16'd1;
  logic        ret_vld = 1'b0;
  logic [2:0]  ret_kind = '0;
  logic [63:0] ret_val = '0;
  logic        peer_vld = 1'b0;
  logic [31:0] peer_sig = '0;
  logic [3:0]  peer_idx = '0;
  logic [31:0] loc_sig;
  logic [3:0]  loc_idx;
  logic        ivl_done, err_flag;

  fp_sig_cmp dut_i (.*);

  int checks = 0, errors = 0;

  function automatic bit [31:0] crc_ref(bit [31:0] c, bit [2:0] k, bit [63:0] d);
    bit [66:0] m = {k, d};
    for (int i = 66; i >= 0; i--) begin
      c[31] = c[31] ^ m[i];
      if (c[31]) c = (c << 1) ^ P_GEN;
      else       c = c << 1;
    end
    return c;
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // behavioural reference model
  bit [31:0] m_acc = P_INIT, m_sig = 0, m_psig = 0;
  int        m_cnt = 0, m_num = 0, m_lidx = 0, m_pidx = 0;
  bit        m_done = 0, m_lv = 0, m_pv = 0, m_err = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_acc = P_INIT; m_cnt = 0; m_num = 0; m_sig = 0; m_lidx = 0;
      m_done = 0; m_lv = 0; m_pv = 0; m_psig = 0; m_pidx = 0; m_err = 0;
    end else if (!red_en) begin
      m_acc = P_INIT; m_cnt = 0; m_num = 0;
      m_done = 0; m_lv = 0; m_pv = 0; m_err = 0;
    end else begin
      bit both, bad, fin;
      both = m_lv && m_pv;
      bad  = both && (m_sig != m_psig || m_lidx != m_pidx);
      fin  = 0;
      if (ret_vld) begin
        m_acc = crc_ref(m_acc, ret_kind, ret_val);
        m_cnt++;
        if (m_cnt >= int'(ivl_len)) begin
          m_sig = m_acc; m_lidx = m_num; m_num = (m_num + 1) % 16;
          m_acc = P_INIT; m_cnt = 0; fin = 1;
        end
      end
      m_done = fin;
      m_lv = (m_lv && !both) || fin;
      m_pv = (m_pv && !both) || peer_vld;
      if (peer_vld) begin m_psig = peer_sig; m_pidx = int'(peer_idx); end
      if (bad) m_err = 1;
      else if (err_clr) m_err = 0;
    end
  end

  always @(negedge clk) if (rst_n) begin
    chk("R2 loc_sig vs model", loc_sig, m_sig);
    chk("R4 ivl_done vs model", ivl_done, m_done);
    chk("R4 loc_idx vs model", loc_idx, m_lidx[3:0]);
    chk("R6 err_flag vs model", err_flag, m_err);
  end

  task automatic item(bit [2:0] k, bit [63:0] v);
    ret_vld = 1; ret_kind = k; ret_val = v;
    @(negedge clk);
    ret_vld = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_peer(bit [31:0] s, bit [3:0] ix);
    peer_vld = 1; peer_sig = s; peer_idx = ix;
    @(negedge clk);
    peer_vld = 0;
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    bit [31:0] s0, s1, sa, sb, exp3, keep;
    bit [63:0] va = 64'h0123456789ABCDEF, vb = 64'hFEDCBA9876543210, vc = 64'h00000000DEADBEEF;
    idle(3);
    chk("R1 err_flag in reset", err_flag, 0);
    chk("R1 ivl_done in reset", ivl_done, 0);
    chk("R1 loc_sig in reset", loc_sig, 0);
    chk("R1 loc_idx in reset", loc_idx, 0);
    rst_n = 1; red_en = 1; ivl_len = 1;
    idle(1);

    item(3'd5, va);
    chk("R4 done after one item", ivl_done, 1);
    chk("R2 single item crc", loc_sig, crc_ref(P_INIT, 3'd5, va));
    chk("R4 first index", loc_idx, 0);
    s0 = loc_sig;
    send_peer(s0, 4'd0);
    idle(2);
    chk("R6 matching peer no error", err_flag, 0);

    item(3'd2, va);
    s1 = loc_sig;
    chk("R3 kind changes signature", s1 == s0, 0);
    chk("R4 second index", loc_idx, 1);
    send_peer(s1 ^ 32'h1, 4'd1);
    idle(1);
    chk("R6 mismatch flagged", err_flag, 1);
    idle(3);
    chk("R7 error sticky", err_flag, 1);
    err_clr = 1; @(negedge clk); err_clr = 0;
    chk("R7 error cleared", err_flag, 0);

    ivl_len = 3;
    item(3'd1, va); item(3'd4, vb);
    chk("R4 no done before count", ivl_done, 0);
    item(3'd6, vc);
    chk("R4 done at count", ivl_done, 1);
    sa = loc_sig;
    exp3 = crc_ref(crc_ref(crc_ref(P_INIT, 3'd1, va), 3'd4, vb), 3'd6, vc);
    chk("R2 three item chain", sa, exp3);
    item(3'd1, va); idle(1); item(3'd4, vb); idle(2); item(3'd6, vc);
    sb = loc_sig;
    chk("R5 reseed gives same sig", sb, sa);
    chk("R3 idle gaps no effect", sb, exp3);

    send_peer(sb, loc_idx + 4'd1);
    idle(1);
    chk("R6 index mismatch flagged", err_flag, 1);
    err_clr = 1; item(3'd0, vb); err_clr = 0;

    ivl_len = 0;
    item(3'd7, vc);
    chk("R4 zero length acts as one", ivl_done, 1);

    keep = loc_sig;
    red_en = 0;
    item(3'd3, va);
    chk("R8 disabled no done", ivl_done, 0);
    send_peer(~keep, 4'd9);
    idle(2);
    chk("R8 disabled no error", err_flag, 0);
    chk("R8 disabled sig held", loc_sig, keep);
    red_en = 1; ivl_len = 1;
    item(3'd3, va);
    chk("R8 index restarts", loc_idx, 0);

    ivl_len = 4;
    for (int n = 0; n < 400; n++) begin
      ret_vld  = ($urandom_range(0, 3) != 0);
      ret_kind = 3'($urandom);
      ret_val  = {$urandom, $urandom};
      peer_vld = ($urandom_range(0, 9) == 0);
      peer_sig = (n % 3 == 0) ? 32'($urandom) : loc_sig;
      peer_idx = loc_idx;
      err_clr  = ($urandom_range(0, 15) == 0);
      if (n % 97 == 0) ivl_len = 16'($urandom_range(0, 6));
      @(negedge clk);
    end
    ret_vld = 0; peer_vld = 0; err_clr = 0;
    idle(3);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule